// File: doc/BRIEF.md
# Gold-Code Spreading Sequence Generator

This block produces the 1023-chip pseudo-random spreading code for one channel of a satellite navigation receiver. Two 10-stage linear feedback shift registers are combined by exclusive-OR. The first register always starts from all ones. The second register starts from a programmable seed, and that seed picks which satellite code is produced. The code passes through a three-tap delay line that is advanced once per half chip. The taps give early, prompt and late replicas, each half a chip apart. An early-minus-late indication and a selectable tracking-arm output are derived from these taps.

Software writes a new seed at any time. The block holds the seed as pending and loads it into the second register only when a restart strobe arrives. The running period is therefore never corrupted part way through. A restart also presets the delay line to ones. Because of this, the first chip after every restart reads as 1, and later periods are exact. A test bit forces the replicas to a fixed pattern. An all-zero seed leaves the second register stuck at zero, so only the first register's sequence appears. This is a test-only case.

The block is clocked by the system clock. It advances only on cycles where the half-chip strobe is high.

Top module: `gold_code_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, early, prompt and late are 1 and epoch is 0. The pending seed and the active seed are both RESET_SEED (default 10'h3F6).
- R2: The first register feeds back the XOR of stages 3 and 10. The second register feeds back the XOR of stages 2, 3, 6, 8, 9 and 10. Each register shifts toward stage 10. The chip value is stage 10 of the first register XOR stage 10 of the second. Seed bit i sets stage i+1 of the second register, and the first register is all ones. These are the register states for the second chip after a restart.
- R3: The code repeats every 1023 chips. Chip indices run 0 to 1022 from a restart. epoch is 1 exactly while the current chip index is 1022.
- R4: A seed written with seed_wr does not alter the running sequence. It is loaded at the next restart. When seed_wr and restart are high in the same cycle, the newly written value is the one loaded.
- R5: A restart presets all three delay taps to 1. Chip index 0 after a restart is forced to 1.
- R6: On each half_chip_en, early takes the current chip value, prompt takes the old early and late takes the old prompt. Every two strobes complete one chip.
- R7: eml is early XOR late.
- R8: track_sel selects track_out as follows: 2'b00 gives early, 2'b01 gives late, 2'b10 gives eml and 2'b11 gives prompt.
- R9: While code_off is 1, early, prompt and late read 1 and eml reads 0. track_out follows these forced values. The generator keeps running underneath.
- R10: With a seed of zero, the second register stays at zero and the chip sequence is the first register's sequence alone.
- R11: With half_chip_en low and no restart, all outputs and all internal sequence state hold.
- R12: A restart takes priority over a half_chip_en in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_chip_en | input | 1 | Half-chip advance strobe |
| restart | input | 1 | Restart the code period and load the pending seed |
| seed_wr | input | 1 | Write seed_val into the pending seed |
| seed_val | input | 10 | Second-register seed (state at the second chip) |
| code_off | input | 1 | Test mode: force the replicas high and eml low |
| track_sel | input | 2 | Tracking-arm code select |
| early | output | 1 | Early replica |
| prompt | output | 1 | Prompt replica |
| late | output | 1 | Late replica |
| eml | output | 1 | Early-minus-late indication |
| track_out | output | 1 | Selected tracking-arm code |
| epoch | output | 1 | High during the last chip of the period |

## Verification
The bench writes seeds in the middle of a period. A design that loaded the seed at once would break the running code within one chip. The bench also writes a seed in the same cycle as a restart, where a design that loaded the stale register would produce the wrong satellite code. It runs more than one full period with continuous, alternating and random strobes. An off-by-one chip counter would show up as epoch in the wrong chip, and a wrong first-chip rule would break the forced leading 1 or every later period. Further runs cover a zero seed, a restart together with a strobe, and long freezes. In those runs, a design that stepped the register while idle or let the strobe beat the restart would drift away from the reference on every later chip.

// File: rtl/gc_pkg.sv
`timescale 1ns/1ps
package gc_pkg;
    localparam int unsigned GC_STAGES = 10;
    // feedback masks: bit k-1 set means stage k is tapped
    localparam logic [GC_STAGES-1:0] GC_G1_TAPS = 10'h204;
    localparam logic [GC_STAGES-1:0] GC_G2_TAPS = 10'h3A6;

    typedef enum logic [1:0] {
        TRK_EARLY  = 2'b00,
        TRK_LATE   = 2'b01,
        TRK_EML    = 2'b10,
        TRK_PROMPT = 2'b11
    } trk_sel_e;
endpackage

// File: rtl/gc_lfsr.sv
`timescale 1ns/1ps
module gc_lfsr #(
    parameter int unsigned        STAGES  = 10,
    parameter logic [STAGES-1:0]  TAPS    = 10'h204,
    parameter logic [STAGES-1:0]  RST_VAL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [STAGES-1:0] load_val,
    output logic              out_bit
);
    typedef struct packed {
        logic [STAGES-1:0] sr;
    } lfsr_st_t;

    lfsr_st_t st_d, st_q;
    logic     fb;

    always_comb begin
        fb   = ^(st_q.sr & TAPS);
        st_d = st_q;
        if (load) begin
            st_d.sr = load_val;
        end else if (step) begin
            st_d.sr = {st_q.sr[STAGES-2:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sr: RST_VAL};
        else        st_q <= st_d;
    end

    assign out_bit = st_q.sr[STAGES-1];

    // a zero register never leaves zero unless reloaded
    assert_zero_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sr == '0 && !load) |=> (st_q.sr == '0));

    // no load and no step: state holds
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(st_q.sr));
endmodule

// File: rtl/gc_chip_seq.sv
`timescale 1ns/1ps
module gc_chip_seq #(
    parameter int unsigned LEN = 1023
) (
    input  logic clk,
    input  logic rst_n,
    input  logic half_en,
    input  logic restart,
    output logic first,
    output logic epoch,
    output logic lfsr_step
);
    localparam int unsigned   CW   = $clog2(LEN);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    typedef struct packed {
        logic          phase;
        logic          first;
        logic [CW-1:0] cnt;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    chip_end;

    always_comb begin
        st_d     = st_q;
        chip_end = half_en && st_q.phase && !restart;
        if (restart) begin
            st_d.phase = 1'b0;
            st_d.first = 1'b1;
            st_d.cnt   = '0;
        end else if (half_en) begin
            st_d.phase = ~st_q.phase;
            if (st_q.phase) begin
                st_d.first = 1'b0;
                st_d.cnt   = (st_q.cnt == LAST) ? '0 : st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: 1'b0, first: 1'b1, cnt: '0};
        else        st_q <= st_d;
    end

    assign first     = st_q.first;
    assign epoch     = (st_q.cnt == LAST);
    assign lfsr_step = chip_end && !st_q.first;

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (half_en && !restart && st_q.phase && st_q.cnt == LAST)
        |=> (st_q.cnt == '0 && !st_q.first));

    assert_restart_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.first && st_q.cnt == '0 && !st_q.phase));
endmodule

// File: rtl/gc_tap_line.sv
`timescale 1ns/1ps
module gc_tap_line #(
    parameter int unsigned TAPS = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            half_en,
    input  logic            restart,
    input  logic            din,
    output logic [TAPS-1:0] taps
);
    typedef struct packed {
        logic [TAPS-1:0] bits;
    } line_st_t;

    line_st_t        st_d, st_q;
    logic [TAPS-1:0] shifted;

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        if (i == 0) begin : g_head
            assign shifted[i] = din;
        end else begin : g_body
            assign shifted[i] = st_q.bits[i-1];
        end
    end

    always_comb begin
        st_d = st_q;
        if (restart)      st_d.bits = '1;
        else if (half_en) st_d.bits = shifted;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{bits: '1};
        else        st_q <= st_d;
    end

    assign taps = st_q.bits;

    assert_preset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.bits == '1));

    assert_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (half_en && !restart) |=> (st_q.bits[TAPS-1:1] == $past(st_q.bits[TAPS-2:0])));

    assert_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!half_en && !restart) |=> $stable(st_q.bits));
endmodule

// File: rtl/gold_code_gen.sv
`timescale 1ns/1ps
module gold_code_gen
    import gc_pkg::*;
#(
    parameter int unsigned           STAGES     = GC_STAGES,
    parameter logic [STAGES-1:0]     G1_TAPS    = GC_G1_TAPS,
    parameter logic [STAGES-1:0]     G2_TAPS    = GC_G2_TAPS,
    parameter logic [STAGES-1:0]     RESET_SEED = 10'h3F6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_chip_en,
    input  logic              restart,
    input  logic              seed_wr,
    input  logic [STAGES-1:0] seed_val,
    input  logic              code_off,
    input  logic [1:0]        track_sel,
    output logic              early,
    output logic              prompt,
    output logic              late,
    output logic              eml,
    output logic              track_out,
    output logic              epoch
);
    localparam int unsigned       CODE_LEN = (1 << STAGES) - 1;
    localparam int unsigned       N_TAPS   = 3;
    localparam logic [STAGES-1:0] G1_START = '1;

    typedef struct packed {
        logic [STAGES-1:0] pend;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic [STAGES-1:0] seed_src;
    logic              g1_bit, g2_bit, chip_bit;
    logic              first, lfsr_step;
    logic [N_TAPS-1:0] taps;

    // seed written in the same cycle as a restart is the one loaded
    always_comb begin
        seed_src = seed_wr ? seed_val : st_q.pend;
        st_d     = st_q;
        st_d.pend = seed_src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pend: RESET_SEED};
        else        st_q <= st_d;
    end

    gc_chip_seq #(.LEN(CODE_LEN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_en   (half_chip_en),
        .restart   (restart),
        .first     (first),
        .epoch     (epoch),
        .lfsr_step (lfsr_step)
    );

    gc_lfsr #(.STAGES(STAGES), .TAPS(G1_TAPS), .RST_VAL(G1_START)) u_g1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (restart),
        .step     (lfsr_step),
        .load_val (G1_START),
        .out_bit  (g1_bit)
    );

    gc_lfsr #(.STAGES(STAGES), .TAPS(G2_TAPS), .RST_VAL(RESET_SEED)) u_g2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (restart),
        .step     (lfsr_step),
        .load_val (seed_src),
        .out_bit  (g2_bit)
    );

    assign chip_bit = first | (g1_bit ^ g2_bit);

    gc_tap_line #(.TAPS(N_TAPS)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .half_en (half_chip_en),
        .restart (restart),
        .din     (chip_bit),
        .taps    (taps)
    );

    always_comb begin
        if (code_off) begin
            early  = 1'b1;
            prompt = 1'b1;
            late   = 1'b1;
            eml    = 1'b0;
        end else begin
            early  = taps[0];
            prompt = taps[1];
            late   = taps[2];
            eml    = taps[0] ^ taps[2];
        end
        case (trk_sel_e'(track_sel))
            TRK_EARLY: track_out = early;
            TRK_LATE:  track_out = late;
            TRK_EML:   track_out = eml;
            default:   track_out = prompt;
        endcase
    end

    assert_code_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        code_off |-> (track_out == (track_sel != 2'b10)));

    assert_first_chip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !code_off) |=> (code_off || (early && prompt && late)));
endmodule

// File: tb/gold_code_gen_tb.sv
`timescale 1ns/1ps
module gold_code_gen_tb;
    localparam int LEN = 1023;
    localparam int RST_SEED = 'h3F6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_chip_en = 1'b0, restart = 1'b0, seed_wr = 1'b0, code_off = 1'b0;
    logic [9:0] seed_val = '0;
    logic [1:0] track_sel = 2'b00;
    logic       early, prompt, late, eml, track_out, epoch;

    int total = 0, bad = 0, tcnt = 0;
    bit done = 0, checking = 0;
    string ctx = "base";

    // reference model state
    bit m_code[LEN];
    int m_pend, m_idx, m_first, m_phase, m_e, m_p, m_l;

    always #2.5 clk = ~clk;

    gold_code_gen u_dut (
        .clk(clk), .rst_n(rst_n), .half_chip_en(half_chip_en), .restart(restart),
        .seed_wr(seed_wr), .seed_val(seed_val), .code_off(code_off), .track_sel(track_sel),
        .early(early), .prompt(prompt), .late(late), .eml(eml),
        .track_out(track_out), .epoch(epoch)
    );

    // full period of chips from a seed; index 0 is the chip reached after 1022 steps
    function automatic void build_code(input int seed);
        int a[11], b[11];
        for (int j = 1; j <= 10; j++) begin
            a[j] = 1;
            b[j] = (seed >> (j - 1)) & 1;
        end
        for (int s = 0; s < LEN; s++) begin
            int o, fa, fb;
            o = a[10] ^ b[10];
            if (s < LEN - 1) m_code[s + 1] = o[0];
            else             m_code[0]     = o[0];
            fa = a[3] ^ a[10];
            fb = b[2] ^ b[3] ^ b[6] ^ b[8] ^ b[9] ^ b[10];
            for (int j = 10; j >= 2; j--) begin
                a[j] = a[j - 1];
                b[j] = b[j - 1];
            end
            a[1] = fa;
            b[1] = fb;
        end
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = RST_SEED; build_code(RST_SEED);
            m_idx = 0; m_first = 1; m_phase = 0; m_e = 1; m_p = 1; m_l = 1;
        end else begin
            if (seed_wr) m_pend = seed_val;
            if (restart) begin
                build_code(m_pend);
                m_idx = 0; m_first = 1; m_phase = 0; m_e = 1; m_p = 1; m_l = 1;
            end else if (half_chip_en) begin
                int cb;
                cb = m_first ? 1 : int'(m_code[m_idx]);
                m_l = m_p; m_p = m_e; m_e = cb;
                if (m_phase) begin
                    m_phase = 0; m_first = 0;
                    m_idx = (m_idx == LEN - 1) ? 0 : m_idx + 1;
                end else m_phase = 1;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && checking) begin
            int ee, ep, el, em, et;
            ee = code_off ? 1 : m_e;
            ep = code_off ? 1 : m_p;
            el = code_off ? 1 : m_l;
            em = code_off ? 0 : (m_e ^ m_l);
            case (track_sel)
                2'b00: et = ee;
                2'b01: et = el;
                2'b10: et = em;
                default: et = ep;
            endcase
            chk({early, prompt, late} == {ee[0], ep[0], el[0]},
                {"R2/R6 early/prompt/late ", ctx}, {early, prompt, late}, ee * 4 + ep * 2 + el);
            chk(eml == em[0], {"R7 eml ", ctx}, eml, em);
            chk(track_out == et[0], {"R8 track_out ", ctx}, track_out, et);
            chk(epoch == (m_idx == LEN - 1), {"R3 epoch ", ctx}, epoch, m_idx == LEN - 1);
        end
    end

    task automatic step_in(input int mode);
        @(posedge clk); #1;
        restart = 0; seed_wr = 0;
        case (mode)
            0: half_chip_en = 1;
            1: half_chip_en = ~half_chip_en;
            2: half_chip_en = $urandom_range(0, 1);
            default: half_chip_en = 0;
        endcase
        tcnt++;
        track_sel = 2'((tcnt / 7) % 4);
    endtask

    task automatic run(input int n, input int mode);
        for (int i = 0; i < n; i++) step_in(mode);
    endtask

    task automatic do_restart(input bit he);
        @(posedge clk); #1;
        restart = 1; seed_wr = 0; half_chip_en = he;
        @(posedge clk); #1;
        restart = 0; half_chip_en = 0;
        @(negedge clk);
        chk({early, prompt, late} == 3'b111 || code_off, "R5 taps preset after restart",
            {early, prompt, late}, 7);
        chk(epoch == 1'b0, "R12 restart wins, epoch low", epoch, 0);
    endtask

    task automatic write_seed(input int v, input bit with_restart);
        @(posedge clk); #1;
        seed_wr = 1; seed_val = 10'(v); restart = with_restart; half_chip_en = 0;
        @(posedge clk); #1;
        seed_wr = 0; restart = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk({early, prompt, late} == 3'b111, "R1 reset taps", {early, prompt, late}, 7);
        chk(epoch == 1'b0, "R1 reset epoch", epoch, 0);
        @(posedge clk); #1; rst_n = 1; checking = 1;
        @(negedge clk);
        chk({early, prompt, late} == 3'b111, "R1 first cycle after reset", {early, prompt, late}, 7);

        ctx = "R2 reset seed continuous";
        run(2300, 0);                       // > one period, covers R3 wrap
        ctx = "R3 alternating strobe";
        run(600, 1);

        ctx = "R4 deferred seed";
        write_seed('h3EC, 0);               // must not disturb the running code
        run(400, 2);
        do_restart(0);                      // R5 / R4: now PRN seed 0x3EC
        ctx = "R5 first chip forced";
        run(6, 0);
        ctx = "R2 new seed";
        run(2200, 2);

        ctx = "R9 code off";
        code_off = 1;
        run(120, 0);
        code_off = 0;

        // R11: freeze
        ctx = "R11 freeze";
        run(3, 0);
        @(posedge clk); #1; half_chip_en = 0;
        @(negedge clk);
        begin
            logic [5:0] snap;
            snap = {early, prompt, late, eml, track_out, epoch};
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                chk({early, prompt, late, eml, track_out, epoch} == snap,
                    "R11 outputs hold while idle", {early, prompt, late, eml, track_out, epoch}, snap);
            end
        end
        run(300, 2);

        ctx = "R12 restart with strobe";
        do_restart(1);
        run(500, 0);

        ctx = "R10 zero seed";
        write_seed(0, 0);
        run(50, 0);
        do_restart(0);
        run(2200, 0);

        ctx = "R4 write with restart";
        write_seed('h338, 1);
        @(negedge clk);
        chk({early, prompt, late} == 3'b111, "R4 same-cycle seed restart preset",
            {early, prompt, late}, 7);
        run(2200, 1);

        ctx = "R4 integrity seed";
        write_seed('h2C4, 1);
        run(900, 2);
        code_off = 1;
        ctx = "R9 code off late";
        run(60, 2);
        code_off = 0;
        run(200, 0);

        done = 1;
        checking = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule